// File: doc/BRIEF.md
# Framed Serial Transmitter

This block turns a stream of parallel data words into a framed serial bit stream on a single transmit data line. It also produces a frame sync signal beside that stream. All timing is set by a transmit clock enable, `bitEn`. Each clock cycle in which `bitEn` is high ends one bit slot, and every transmit output is registered at that edge. A frame opens with a sync phase of programmable length. During that phase the line can carry the bits of a separate sync-data word. The sync phase is followed by a programmable number of data words, each of a programmable bit length and bit order.

Software-visible settings arrive as plain input ports. They are captured into a configuration register by a write strobe, and a write-protect input suppresses that capture. A start request opens a frame. Data words are taken over a ready/valid handshake at the start of each word slot. Two sticky flags report a selected edge on the frame sync signal and a word slot that found no data. Both flags are cleared by a clear pulse.

Top module: `sframe_tx`

## Requirements
- R1: Every frame starts with a sync phase of exactly `cfgSyncLen + 16*cfgSyncLenExt + 1` bit slots, and the first data bit follows it directly.
- R2: `cfgSyncMode` shapes the sync output as follows. Code 1 drives it low during the sync phase and high otherwise. Code 2 drives it high during the sync phase and low otherwise. Code 3 drives it low during the data phase and high otherwise. Code 4 drives it high during the data phase and low otherwise. Code 5 inverts it at each frame start. With codes 1 to 5, `syncOe` is 1. Codes 0, 6 and 7 give `syncOe` = 0 and `syncOut` = 0.
- R3: With `cfgSyncDataEn` = 1, sync slot i (counting from 0) carries `cfgSyncData[i]` for i < SYNC_W, and carries the idle level for higher i. With `cfgSyncDataEn` = 0, every sync slot carries the idle level.
- R4: A frame carries `cfgWordCnt + 1` words, and each word carries `cfgWordLen + 1` bits. A `cfgWordLen` of 0 is illegal and is treated as 1, which gives 2-bit words.
- R5: With `cfgMsbFirst` = 1, bit `cfgWordLen` of a word is sent first and bit 0 last. With `cfgMsbFirst` = 0, the order is reversed.
- R6: Outside a frame, `txData` holds `cfgIdleLvl`.
- R7: On each enabled edge, `syncFlag` sets when the watched sync signal has a rising edge (`cfgSyncEdge` = 0) or a falling edge (`cfgSyncEdge` = 1) between its two previous enabled samples. The watched signal is `syncOut` for codes 1 to 5. For any other code it is `syncIn`, sampled on enabled edges.
- R8: While `wrProtect` is high, a `cfgWrite` pulse leaves the configuration unchanged.
- R9: If `wordValid` is low when a word slot begins, that word's bits hold the idle level and `underrun` sets. It stays set until `clrFlags`.
- R10: `wordReady` is high only in an enabled cycle whose edge begins the first bit of a word. The word is sampled when `wordValid` is also high in that cycle.
- R11: `txData`, `syncOut` and `syncOe` change only at edges where `bitEn` is high. `clrFlags` clears both flags at any edge, but a new event on that edge takes priority over the clear.
- R12: A start request is held until a frame begins. A request made during a frame starts the next frame in the slot right after the last data bit, with no idle slot in between.
- R13: After reset, all outputs are 0 and the configuration is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | Transmit clock enable; ends one bit slot |
| cfgWrite | input | 1 | Configuration capture strobe |
| wrProtect | input | 1 | Blocks configuration capture |
| cfgSyncLen | input | 4 | Sync length, low part |
| cfgSyncLenExt | input | 4 | Sync length, high part (times 16) |
| cfgSyncMode | input | 3 | Sync output shape code |
| cfgSyncDataEn | input | 1 | Send sync-data bits during sync |
| cfgSyncEdge | input | 1 | Flag edge: 0 rising, 1 falling |
| cfgWordCnt | input | 4 | Words per frame minus one |
| cfgWordLen | input | 5 | Bits per word minus one |
| cfgMsbFirst | input | 1 | Bit order select |
| cfgIdleLvl | input | 1 | Line level outside transmission |
| cfgSyncData | input | SYNC_W | Sync-data word |
| startReq | input | 1 | Frame start request |
| wordData | input | DATA_W | Data word |
| wordValid | input | 1 | Data word available |
| wordReady | output | 1 | Data word taken this cycle |
| syncIn | input | 1 | External sync, watched for codes 0, 6 and 7 |
| clrFlags | input | 1 | Clears both flags |
| txData | output | 1 | Serial data line |
| syncOut | output | 1 | Frame sync level |
| syncOe | output | 1 | Frame sync output enable |
| syncFlag | output | 1 | Sticky sync-edge flag |
| underrun | output | 1 | Sticky missing-word flag |

## Verification
Frames are sent with a steady enable and with an enable that skips every third cycle. A cycle-exact reference compares every output on every cycle. This separates bit-slot counting from plain cycle counting. Several shapes are tried: a short MSB-first pulse frame, an LSB-first frame with 2-bit words and sync data, two frames back to back with the toggle shape, and a sync phase longer than the sync-data word. These tell apart the phase boundaries, the bit order, the clamped word length and the idle fill past the end of the sync-data word. A blocked configuration write, a starved word slot and an externally toggled sync input each change one condition, which exposes the write protect, the underrun path and the flag's edge select.

// File: rtl/sframe_tx_pkg.sv
package sframe_tx_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_SYNC, PH_DATA} phase_e;
  typedef enum logic [1:0] {LN_IDLE, LN_SYNC, LN_DATA} lineSel_e;

  // configuration fields consumed by the control path
  typedef struct packed {
    logic [3:0] syncLen;
    logic [3:0] syncLenExt;
    logic [2:0] syncMode;
    logic       syncDataEn;
    logic       syncEdge;
    logic [3:0] wordCnt;
    logic [4:0] wordLen;
    logic       msbFirst;
  } cfg_t;

  // strobes from control to datapath, describing the slot about to start
  typedef struct packed {
    logic       slotEn;
    logic       loadWord;
    lineSel_e   lineSel;
    logic [7:0] syncIdx;
    logic [4:0] bitIdx;
  } strb_t;

endpackage

// File: rtl/sframe_tx_cfg.sv
module sframe_tx_cfg
  import sframe_tx_pkg::*;
#(
  parameter int SYNC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic              wrProtect,
  input  cfg_t              cfgNext,
  input  logic              idleNext,
  input  logic [SYNC_W-1:0] syncDataNext,
  output cfg_t              cfgQ,
  output logic              idleQ,
  output logic [SYNC_W-1:0] syncDataQ
);

  logic capture;
  assign capture = cfgWrite & ~wrProtect;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ      <= '0;
      idleQ     <= 1'b0;
      syncDataQ <= '0;
    end else if (capture) begin
      cfgQ      <= cfgNext;
      idleQ     <= idleNext;
      syncDataQ <= syncDataNext;
    end
  end

endmodule

// File: rtl/sframe_tx_ctrl.sv
module sframe_tx_ctrl
  import sframe_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  bitEn,
  input  cfg_t  cfg,
  input  logic  startReq,
  input  logic  wordValid,
  input  logic  syncIn,
  input  logic  clrFlags,
  output strb_t strb,
  output logic  wordReady,
  output logic  syncOut,
  output logic  syncOe,
  output logic  syncFlag,
  output logic  underrun
);

  localparam logic [2:0] MODE_NEG  = 3'd1;
  localparam logic [2:0] MODE_POS  = 3'd2;
  localparam logic [2:0] MODE_LOW  = 3'd3;
  localparam logic [2:0] MODE_HIGH = 3'd4;
  localparam logic [2:0] MODE_TOG  = 3'd5;

  phase_e     phase, nPhase;
  logic [7:0] syncCnt, nSyncCnt;
  logic [4:0] bitCnt, nBitCnt;
  logic [3:0] wordCnt, nWordCnt;
  logic       pend, wordOk, nWordOk, tog, nTog;
  logic       syncInS, syncPrev;
  logic       frameStart, wordStart, startNow, modeOn, nSyncLvl, sEff, edgeHit;
  logic [7:0] syncLast;
  logic [4:0] effLen;

  assign syncLast = {cfg.syncLenExt, cfg.syncLen};
  assign effLen   = (cfg.wordLen == 5'd0) ? 5'd1 : cfg.wordLen;
  assign startNow = pend | startReq;
  assign modeOn   = (cfg.syncMode >= MODE_NEG) && (cfg.syncMode <= MODE_TOG);

  // next-slot sequencing
  always_comb begin
    nPhase     = phase;
    nSyncCnt   = syncCnt;
    nBitCnt    = bitCnt;
    nWordCnt   = wordCnt;
    frameStart = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (startNow) begin
          nPhase     = PH_SYNC;
          nSyncCnt   = 8'd0;
          frameStart = 1'b1;
        end
      end
      PH_SYNC: begin
        if (syncCnt >= syncLast) begin
          nPhase   = PH_DATA;
          nBitCnt  = 5'd0;
          nWordCnt = 4'd0;
        end else begin
          nSyncCnt = syncCnt + 8'd1;
        end
      end
      PH_DATA: begin
        if (bitCnt < effLen) begin
          nBitCnt = bitCnt + 5'd1;
        end else if (wordCnt < cfg.wordCnt) begin
          nBitCnt  = 5'd0;
          nWordCnt = wordCnt + 4'd1;
        end else if (startNow) begin
          nPhase     = PH_SYNC;
          nSyncCnt   = 8'd0;
          frameStart = 1'b1;
        end else begin
          nPhase = PH_IDLE;
        end
      end
      default: nPhase = PH_IDLE;
    endcase
  end

  assign wordStart = (nPhase == PH_DATA) && (nBitCnt == 5'd0);
  assign wordReady = bitEn & wordStart;
  assign nWordOk   = wordStart ? wordValid : wordOk;
  assign nTog      = (frameStart && cfg.syncMode == MODE_TOG) ? ~tog : tog;

  // strobes to the datapath
  always_comb begin
    strb.slotEn   = bitEn;
    strb.loadWord = bitEn & wordStart & wordValid;
    strb.syncIdx  = nSyncCnt;
    strb.bitIdx   = cfg.msbFirst ? (effLen - nBitCnt) : nBitCnt;
    unique case (nPhase)
      PH_SYNC: strb.lineSel = cfg.syncDataEn ? LN_SYNC : LN_IDLE;
      PH_DATA: strb.lineSel = nWordOk ? LN_DATA : LN_IDLE;
      default: strb.lineSel = LN_IDLE;
    endcase
  end

  // sync shape for the next slot
  always_comb begin
    unique case (cfg.syncMode)
      MODE_NEG:  nSyncLvl = (nPhase != PH_SYNC);
      MODE_POS:  nSyncLvl = (nPhase == PH_SYNC);
      MODE_LOW:  nSyncLvl = (nPhase != PH_DATA);
      MODE_HIGH: nSyncLvl = (nPhase == PH_DATA);
      MODE_TOG:  nSyncLvl = nTog;
      default:   nSyncLvl = 1'b0;
    endcase
  end

  assign sEff    = modeOn ? syncOut : syncInS;
  assign edgeHit = cfg.syncEdge ? (syncPrev & ~sEff) : (~syncPrev & sEff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      syncCnt  <= '0;
      bitCnt   <= '0;
      wordCnt  <= '0;
      pend     <= 1'b0;
      wordOk   <= 1'b0;
      tog      <= 1'b0;
      syncOut  <= 1'b0;
      syncOe   <= 1'b0;
      syncInS  <= 1'b0;
      syncPrev <= 1'b0;
      syncFlag <= 1'b0;
      underrun <= 1'b0;
    end else begin
      pend     <= (bitEn & frameStart) ? 1'b0 : startNow;
      syncFlag <= (bitEn & edgeHit) | (syncFlag & ~clrFlags);
      underrun <= (bitEn & wordStart & ~wordValid) | (underrun & ~clrFlags);
      if (bitEn) begin
        phase    <= nPhase;
        syncCnt  <= nSyncCnt;
        bitCnt   <= nBitCnt;
        wordCnt  <= nWordCnt;
        wordOk   <= nWordOk;
        tog      <= nTog;
        syncOut  <= nSyncLvl;
        syncOe   <= modeOn;
        syncInS  <= syncIn;
        syncPrev <= sEff;
      end
    end
  end

endmodule

// File: rtl/sframe_tx_dp.sv
module sframe_tx_dp
  import sframe_tx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYNC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic [DATA_W-1:0] wordData,
  input  logic [SYNC_W-1:0] syncData,
  input  logic              idleLvl,
  output logic              txData
);

  logic [DATA_W-1:0] wordReg, srcWord;
  logic              wordBit, syncBit, nextTx;

  assign srcWord = strb.loadWord ? wordData : wordReg;

  always_comb begin
    wordBit = idleLvl;
    for (int i = 0; i < DATA_W; i++)
      if (i == int'(strb.bitIdx)) wordBit = srcWord[i];
  end

  always_comb begin
    syncBit = idleLvl;
    for (int i = 0; i < SYNC_W; i++)
      if (i == int'(strb.syncIdx)) syncBit = syncData[i];
  end

  always_comb begin
    unique case (strb.lineSel)
      LN_SYNC: nextTx = syncBit;
      LN_DATA: nextTx = wordBit;
      default: nextTx = idleLvl;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
      txData  <= 1'b0;
    end else begin
      if (strb.loadWord) wordReg <= wordData;
      if (strb.slotEn)   txData  <= nextTx;
    end
  end

endmodule

// File: rtl/sframe_tx.sv
module sframe_tx
  import sframe_tx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYNC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              cfgWrite,
  input  logic              wrProtect,
  input  logic [3:0]        cfgSyncLen,
  input  logic [3:0]        cfgSyncLenExt,
  input  logic [2:0]        cfgSyncMode,
  input  logic              cfgSyncDataEn,
  input  logic              cfgSyncEdge,
  input  logic [3:0]        cfgWordCnt,
  input  logic [4:0]        cfgWordLen,
  input  logic              cfgMsbFirst,
  input  logic              cfgIdleLvl,
  input  logic [SYNC_W-1:0] cfgSyncData,
  input  logic              startReq,
  input  logic [DATA_W-1:0] wordData,
  input  logic              wordValid,
  output logic              wordReady,
  input  logic              syncIn,
  input  logic              clrFlags,
  output logic              txData,
  output logic              syncOut,
  output logic              syncOe,
  output logic              syncFlag,
  output logic              underrun
);

  cfg_t              cfgNext, cfgQ;
  logic              idleQ;
  logic [SYNC_W-1:0] syncDataQ;
  strb_t             strb;

  assign cfgNext = '{syncLen:    cfgSyncLen,
                     syncLenExt: cfgSyncLenExt,
                     syncMode:   cfgSyncMode,
                     syncDataEn: cfgSyncDataEn,
                     syncEdge:   cfgSyncEdge,
                     wordCnt:    cfgWordCnt,
                     wordLen:    cfgWordLen,
                     msbFirst:   cfgMsbFirst};

  sframe_tx_cfg #(.SYNC_W(SYNC_W)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .wrProtect(wrProtect),
    .cfgNext(cfgNext), .idleNext(cfgIdleLvl), .syncDataNext(cfgSyncData),
    .cfgQ(cfgQ), .idleQ(idleQ), .syncDataQ(syncDataQ)
  );

  sframe_tx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .cfg(cfgQ), .startReq(startReq),
    .wordValid(wordValid), .syncIn(syncIn), .clrFlags(clrFlags), .strb(strb),
    .wordReady(wordReady), .syncOut(syncOut), .syncOe(syncOe),
    .syncFlag(syncFlag), .underrun(underrun)
  );

  sframe_tx_dp #(.DATA_W(DATA_W), .SYNC_W(SYNC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wordData(wordData),
    .syncData(syncDataQ), .idleLvl(idleQ), .txData(txData)
  );

endmodule

// File: rtl/sframe_tx_chk.sv
module sframe_tx_chk
  import sframe_tx_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic wrProtect,
  input cfg_t cfgQ,
  input logic wordReady,
  input logic wordValid,
  input logic clrFlags,
  input logic txData,
  input logic syncOut,
  input logic syncOe,
  input logic syncFlag,
  input logic underrun
);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(txData) && $stable(syncOut) && $stable(syncOe));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    clrFlags && !bitEn |=> !syncFlag && !underrun);

  p_ready_en_r10: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> bitEn);

  p_protect_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrProtect |=> $stable(cfgQ));

  p_no_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitEn && (cfgQ.syncMode == 3'd0 || cfgQ.syncMode > 3'd5) |=> !syncOe);

  p_under_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> $past(wordReady && !wordValid));

  p_under_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    underrun && !clrFlags |=> underrun);

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    syncFlag && !clrFlags |=> syncFlag);

endmodule

bind sframe_tx sframe_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .wrProtect(wrProtect), .cfgQ(cfgQ),
  .wordReady(wordReady), .wordValid(wordValid), .clrFlags(clrFlags),
  .txData(txData), .syncOut(syncOut), .syncOe(syncOe),
  .syncFlag(syncFlag), .underrun(underrun)
);

// File: tb/tb_sframe_tx.sv
module tb_sframe_tx;
  localparam int DATA_W = 32;
  localparam int SYNC_W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, bitEn, cfgWrite, wrProtect, cfgSyncDataEn, cfgSyncEdge;
  logic cfgMsbFirst, cfgIdleLvl, startReq, wordValid, wordReady, syncIn;
  logic clrFlags, txData, syncOut, syncOe, syncFlag, underrun;
  logic [3:0] cfgSyncLen, cfgSyncLenExt, cfgWordCnt;
  logic [2:0] cfgSyncMode;
  logic [4:0] cfgWordLen;
  logic [SYNC_W-1:0] cfgSyncData;
  logic [DATA_W-1:0] wordData;

  sframe_tx dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // stimulus controls
  bit runEn = 0, stallEn = 1, toggleIn = 0, hsSeen = 0;
  int enCnt = 0;

  always @(negedge clk) begin
    enCnt++;
    bitEn   <= runEn && (!stallEn || (enCnt % 3) != 2);
    syncIn  <= toggleIn ? enCnt[2] : 1'b0;
    if (hsSeen) begin
      wordData <= wordData + 32'h9E37_79B9;
      hsSeen   <= 0;
    end
  end

  // behavioural reference
  int mSlen, mExt, mMode, mWcnt, mWlen;
  bit mSde, mEdge, mMsb, mIdle;
  logic [SYNC_W-1:0] mSdata;
  int mPh, mSc, mBc, mWc;
  bit mOk, mTog, mPend, mTx, mSync, mOe, mSinS, mSprev, mSflag, mUflag;
  logic [DATA_W-1:0] mWord;
  int L, eff, nph, nsc, nbc, nwc;
  bit fs, ws, setS, setU, sEff, pendIn;

  function automatic bit expReady();
    int last, el;
    last = mSlen + 16 * mExt;
    el = (mWlen == 0) ? 1 : mWlen;
    return bitEn && ((mPh == 1 && mSc >= last) || (mPh == 2 && mBc >= el && mWc < mWcnt));
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSlen = 0; mExt = 0; mMode = 0; mWcnt = 0; mWlen = 0;
      mSde = 0; mEdge = 0; mMsb = 0; mIdle = 0; mSdata = '0;
      mPh = 0; mSc = 0; mBc = 0; mWc = 0; mOk = 0; mTog = 0; mPend = 0;
      mTx = 0; mSync = 0; mOe = 0; mSinS = 0; mSprev = 0; mSflag = 0; mUflag = 0;
      mWord = '0;
    end else begin
      pendIn = mPend || startReq;
      setS = 0; setU = 0;
      if (bitEn) begin
        eff = (mWlen == 0) ? 1 : mWlen;
        L = mSlen + 16 * mExt;
        nph = mPh; nsc = mSc; nbc = mBc; nwc = mWc; fs = 0;
        if (mPh == 0) begin
          if (pendIn) begin nph = 1; nsc = 0; fs = 1; end
        end else if (mPh == 1) begin
          if (mSc >= L) begin nph = 2; nbc = 0; nwc = 0; end else nsc = mSc + 1;
        end else begin
          if (mBc < eff) nbc = mBc + 1;
          else if (mWc < mWcnt) begin nbc = 0; nwc = mWc + 1; end
          else if (pendIn) begin nph = 1; nsc = 0; fs = 1; end
          else nph = 0;
        end
        ws = (nph == 2 && nbc == 0);
        sEff = (mMode >= 1 && mMode <= 5) ? mSync : mSinS;
        setS = mEdge ? (mSprev && !sEff) : (!mSprev && sEff);
        mSprev = sEff;
        mSinS = syncIn;
        if (ws) begin
          if (wordValid) begin mWord = wordData; mOk = 1; end
          else begin mOk = 0; setU = 1; end
        end
        if (fs && mMode == 5) mTog = !mTog;
        if (nph == 0) mTx = mIdle;
        else if (nph == 1) mTx = (mSde && nsc < SYNC_W) ? mSdata[nsc] : mIdle;
        else mTx = mOk ? mWord[mMsb ? eff - nbc : nbc] : mIdle;
        case (mMode)
          1: mSync = (nph != 1);
          2: mSync = (nph == 1);
          3: mSync = (nph != 2);
          4: mSync = (nph == 2);
          5: mSync = mTog;
          default: mSync = 0;
        endcase
        mOe = (mMode >= 1 && mMode <= 5);
        mPh = nph; mSc = nsc; mBc = nbc; mWc = nwc;
        mPend = fs ? 0 : pendIn;
      end else begin
        mPend = pendIn;
      end
      mSflag = setS || (mSflag && !clrFlags);
      mUflag = setU || (mUflag && !clrFlags);
      if (cfgWrite && !wrProtect) begin
        mSlen = cfgSyncLen; mExt = cfgSyncLenExt; mMode = cfgSyncMode;
        mSde = cfgSyncDataEn; mEdge = cfgSyncEdge; mWcnt = cfgWordCnt;
        mWlen = cfgWordLen; mMsb = cfgMsbFirst; mIdle = cfgIdleLvl; mSdata = cfgSyncData;
      end
    end
  end

  // per-cycle comparison, away from the clock edge
  int syncHi = 0, hsCnt = 0;
  bit prevEn = 0, prevOk = 0, pTx, pSy, pOe;
  always begin
    @(negedge clk);
    #3;
    if (rstN && runEn) begin
      chk(txData == mTx, (mPh == 1) ? "R3 txData" : (mPh == 2) ? "R5 txData" : "R6 txData", txData, mTx);
      chk(syncOut == mSync, "R2 syncOut", syncOut, mSync);
      chk(syncOe == mOe, "R2 syncOe", syncOe, mOe);
      chk(wordReady == expReady(), "R10 wordReady", wordReady, expReady());
      chk(syncFlag == mSflag, "R7 syncFlag", syncFlag, mSflag);
      chk(underrun == mUflag, "R9 underrun", underrun, mUflag);
      if (prevOk && !prevEn)
        chk(txData == pTx && syncOut == pSy && syncOe == pOe, "R11 change without enable",
            {txData, syncOut, syncOe}, {pTx, pSy, pOe});
      if (bitEn && syncOut) syncHi++;
      if (wordReady && wordValid) begin hsCnt++; hsSeen = 1; end
      prevOk = 1; prevEn = bitEn; pTx = txData; pSy = syncOut; pOe = syncOe;
    end
  end

  task automatic cfgSet(input int sl, input int ex, input int md, input bit sde, input bit edg,
                        input int wc, input int wl, input bit msb, input bit idl,
                        input logic [SYNC_W-1:0] sd, input bit wp);
    @(negedge clk);
    cfgSyncLen = 4'(sl); cfgSyncLenExt = 4'(ex); cfgSyncMode = 3'(md);
    cfgSyncDataEn = sde; cfgSyncEdge = edg; cfgWordCnt = 4'(wc); cfgWordLen = 5'(wl);
    cfgMsbFirst = msb; cfgIdleLvl = idl; cfgSyncData = sd;
    cfgWrite = 1; wrProtect = wp;
    @(negedge clk);
    cfgWrite = 0; wrProtect = 0;
    repeat (4) @(negedge clk);
    syncHi = 0; hsCnt = 0;
  endtask

  task automatic startFrame();
    @(negedge clk); startReq = 1;
    @(negedge clk); startReq = 0;
  endtask

  task automatic clearPulse();
    @(negedge clk); clrFlags = 1;
    @(negedge clk); clrFlags = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; cfgWrite = 0; wrProtect = 0; cfgSyncLen = 0; cfgSyncLenExt = 0;
    cfgSyncMode = 0; cfgSyncDataEn = 0; cfgSyncEdge = 0; cfgWordCnt = 0;
    cfgWordLen = 0; cfgMsbFirst = 0; cfgIdleLvl = 0; cfgSyncData = '0;
    startReq = 0; wordData = 32'h1234_5678; wordValid = 0; clrFlags = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    #3;
    // R13: reset state
    chk({txData, syncOut, syncOe, wordReady, syncFlag, underrun} == 6'b0, "R13 reset outputs",
        {txData, syncOut, syncOe, wordReady, syncFlag, underrun}, 0);
    @(negedge clk);
    runEn = 1; wordValid = 1;

    // positive pulse, 3-slot sync, 2 words of 8 bits, MSB first, idle high
    cfgSet(2, 0, 2, 0, 0, 1, 7, 1, 1, 16'h0, 0);
    startFrame();
    repeat (60) @(negedge clk);
    chk(syncHi == 3, "R1 sync slots", syncHi, 3);
    chk(hsCnt == 2, "R4 words per frame", hsCnt, 2);

    // negative pulse with sync data, clamped 2-bit words, LSB first
    cfgSet(3, 0, 1, 1, 0, 0, 0, 0, 0, 16'hA5C3, 0);
    startFrame();
    repeat (40) @(negedge clk);
    chk(hsCnt == 1, "R4 single clamped word", hsCnt, 1);

    // toggle shape, back-to-back frames, steady enable
    stallEn = 0;
    cfgSet(0, 0, 5, 1, 1, 2, 3, 1, 0, 16'h3C96, 0);
    startFrame();
    repeat (5) @(negedge clk);
    startFrame();
    repeat (80) @(negedge clk);
    chk(hsCnt == 6, "R12 queued second frame", hsCnt, 6);

    // 18-slot sync, longer than the sync-data word
    stallEn = 1;
    cfgSet(1, 1, 2, 1, 0, 0, 4, 0, 1, 16'hFFFF, 0);
    startFrame();
    repeat (80) @(negedge clk);
    chk(syncHi == 18, "R1 extended sync slots", syncHi, 18);

    // blocked configuration write keeps the previous frame shape
    cfgSet(5, 0, 4, 0, 0, 0, 4, 0, 0, 16'h0, 1);
    startFrame();
    repeat (80) @(negedge clk);
    chk(syncHi == 18, "R8 protected write ignored", syncHi, 18);

    // starved word slots
    cfgSet(2, 0, 4, 0, 0, 1, 5, 0, 1, 16'h0, 0);
    clearPulse();
    wordValid = 0;
    startFrame();
    repeat (60) @(negedge clk);
    chk(underrun == 1, "R9 underrun set", underrun, 1);
    wordValid = 1;
    clearPulse();
    #3;
    chk(underrun == 0, "R11 flag cleared", underrun, 0);

    // external sync watched on falling edges, no drive
    cfgSet(0, 0, 0, 0, 1, 0, 2, 0, 0, 16'h0, 0);
    clearPulse();
    toggleIn = 1;
    repeat (40) @(negedge clk);
    #3;
    chk(syncFlag == 1, "R7 falling edge on input", syncFlag, 1);
    chk(syncOe == 0, "R2 no drive code 0", syncOe, 0);
    cfgSet(0, 0, 6, 0, 0, 0, 2, 0, 0, 16'h0, 0);
    repeat (10) @(negedge clk);
    #3;
    chk(syncOe == 0, "R2 no drive code 6", syncOe, 0);
    toggleIn = 0;

    // low during data, full 32-bit words MSB first
    stallEn = 0;
    cfgSet(1, 0, 3, 0, 0, 0, 31, 1, 0, 16'h0, 0);
    startFrame();
    repeat (60) @(negedge clk);
    chk(hsCnt == 1, "R5 long word taken", hsCnt, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule